// File: doc/BRIEF.md
# Bitmap-Indexed Priority Ready List

This block keeps runnable task IDs sorted into 32 first-in first-out queues, one per priority band, and hands back the most urgent one on request. A 32-bit occupancy word carries one bit per queue, set while that queue holds entries. The next task to serve therefore comes from a single find-first-set over that word, with no walk through the queues. The lowest queue index counts as the most urgent.

An enqueue supplies a task ID and a 7-bit priority. A mode input picks how the priority becomes a queue index. In scaled mode the 128 levels fold four to a queue. In direct mode the low five bits are the queue index. The ID goes to the tail of that queue. A dequeue pops the head of the lowest-numbered non-empty queue. All queues share one storage pool of linked slots with a free list, so the total entry count is bounded by a parameter rather than by a per-queue depth. Each operation finishes in one clock. When both arrive in the same cycle, the enqueue is applied first.

Top module: `ready_list`

## Requirements
- R1: With `enq_direct` = 0, the queue index is the priority divided by four (the upper five of its seven bits), so priorities 0..3 go to queue 0 and 124..127 go to queue 31.
- R2: With `enq_direct` = 1, the queue index is `enq_prio[4:0]`, and bits 6:5 of the priority are ignored.
- R3: Within one queue, IDs leave in the order they were accepted.
- R4: A dequeue always serves the non-empty queue with the lowest index. Its ID appears on `deq_id` with `deq_valid` high for one cycle, in the cycle after the request edge.
- R5: Bit i of `occ` is 1 exactly while queue i holds at least one entry. Without an operation, `occ` and `full` keep their values.
- R6: A dequeue request while every queue is empty, and with no enqueue in the same cycle, raises `deq_none` for one cycle after the edge. `deq_valid` stays low, and no entry changes. Without a request, neither output rises.
- R7: When `NTASK` entries are held, `full` is 1. An enqueue in that state is dropped, `enq_drop` pulses one cycle after the edge, and the held contents do not change. A dequeue in the same cycle does not make room for it.
- R8: When an enqueue and a dequeue arrive in the same cycle, the enqueue takes effect first. If it targets a more urgent or otherwise empty band, the dequeue returns that same new ID.
- R9: After reset, `occ` is 0, and `full`, `deq_valid`, `deq_none` and `enq_drop` are 0.
- R10: Slots freed by dequeues are reused. After the list is filled and drained, `NTASK` further enqueues are all accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue request this cycle |
| enq_id | input | ID_W (8) | Task ID to enqueue |
| enq_prio | input | PRIO_W (7) | Priority of the task |
| enq_direct | input | 1 | 1: direct queue index, 0: scaled mapping |
| deq_req | input | 1 | Dequeue request this cycle |
| deq_valid | output | 1 | Registered: a task was dequeued |
| deq_id | output | ID_W (8) | Registered: the dequeued task ID |
| deq_none | output | 1 | Registered: the dequeue found every queue empty |
| enq_drop | output | 1 | Registered: the enqueue was dropped because storage was full |
| full | output | 1 | All storage slots are in use |
| occ | output | NQ (32) | Occupancy word, one bit per queue |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. One is an enqueue and a dequeue landing on a queue that holds a single entry. The other is both landing on an empty list, where the new ID must pass straight through. Reaching either needs exact control of queue contents at the moment of collision. Directed sequences set up each case: an empty list, a one-entry queue, and a completely full pool. Seeded random phases then alternate between fill-heavy and drain-heavy mixes, so the pool keeps crossing both its full and empty boundaries while collisions land on random bands.

// File: rtl/ready_list_pkg.sv
package ready_list_pkg;

  typedef enum logic {
    MAP_SCALED = 1'b0,
    MAP_DIRECT = 1'b1
  } map_mode_e;

endpackage

// File: rtl/ready_list_prio_map.sv
module ready_list_prio_map #(
  parameter int PRIO_W = 7,
  parameter int QW     = 5
) (
  input  logic [PRIO_W-1:0] prio,
  input  logic              direct,
  output logic [QW-1:0]     qidx
);
  import ready_list_pkg::*;

  function automatic logic [QW-1:0] band_of(input logic [PRIO_W-1:0] p,
                                            input map_mode_e m);
    if (m == MAP_DIRECT) return p[QW-1:0];
    return p[PRIO_W-1 -: QW];
  endfunction

  assign qidx = band_of(prio, map_mode_e'(direct));

endmodule

// File: rtl/ready_list_ffs.sv
module ready_list_ffs #(
  parameter int W  = 32,
  parameter int IW = 5
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);

  function automatic logic [IW-1:0] first_set(input logic [W-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign idx = first_set(vec);
  assign any = |vec;

endmodule

// File: rtl/ready_list.sv
module ready_list #(
  parameter int NQ     = 32,
  parameter int PRIO_W = 7,
  parameter int ID_W   = 8,
  parameter int NTASK  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic [ID_W-1:0]   enq_id,
  input  logic [PRIO_W-1:0] enq_prio,
  input  logic              enq_direct,
  input  logic              deq_req,
  output logic              deq_valid,
  output logic [ID_W-1:0]   deq_id,
  output logic              deq_none,
  output logic              enq_drop,
  output logic              full,
  output logic [NQ-1:0]     occ
);

  localparam int QW = $clog2(NQ);
  localparam int PW = $clog2(NTASK);
  localparam int CW = $clog2(NTASK + 1);

  // queue and storage state
  logic [PW-1:0]   head [NQ];
  logic [PW-1:0]   tail [NQ];
  logic [PW-1:0]   nxt  [NTASK];
  logic [ID_W-1:0] idmem[NTASK];
  logic [PW-1:0]   free_head;
  logic [CW-1:0]   used;

  // named internal events
  logic [QW-1:0] enq_qidx;
  logic          enq_ok;
  logic [PW-1:0] alloc;
  logic [NQ-1:0] occ_post;
  logic [QW-1:0] sel_q;
  logic          sel_any;
  logic          deq_go;
  logic          pass_thru;
  logic [PW-1:0] pop_slot;
  logic [PW-1:0] pop_next;
  logic          pop_drains;
  logic          enq_same_q;

  ready_list_prio_map #(.PRIO_W(PRIO_W), .QW(QW)) u_map (
    .prio   (enq_prio),
    .direct (enq_direct),
    .qidx   (enq_qidx)
  );

  assign full     = (used == CW'(NTASK));
  assign enq_ok   = enq_valid && !full;
  assign alloc    = free_head;
  assign occ_post = occ | (enq_ok ? (NQ'(1) << enq_qidx) : '0);

  ready_list_ffs #(.W(NQ), .IW(QW)) u_ffs (
    .vec (occ_post),
    .idx (sel_q),
    .any (sel_any)
  );

  assign deq_go     = deq_req && sel_any;
  assign enq_same_q = enq_ok && (enq_qidx == sel_q);
  assign pass_thru  = deq_go && enq_same_q && !occ[sel_q];
  assign pop_slot   = head[sel_q];
  assign pop_next   = (enq_same_q && pop_slot == tail[sel_q]) ? alloc : nxt[pop_slot];
  assign pop_drains = (pop_slot == tail[sel_q]) && !enq_same_q;

  // ID payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (enq_ok) idmem[alloc] <= enq_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ       <= '0;
      free_head <= '0;
      used      <= '0;
      for (int i = 0; i < NQ; i++) begin
        head[i] <= '0;
        tail[i] <= '0;
      end
      for (int i = 0; i < NTASK; i++) nxt[i] <= PW'((i + 1) % NTASK);
    end else begin
      used <= used + CW'(enq_ok) - CW'(deq_go);
      // enqueue first
      if (enq_ok) begin
        if (occ[enq_qidx]) nxt[tail[enq_qidx]] <= alloc;
        else               head[enq_qidx]      <= alloc;
        tail[enq_qidx] <= alloc;
        occ[enq_qidx]  <= 1'b1;
      end
      // then dequeue
      if (pass_thru) begin
        occ[sel_q] <= 1'b0;
      end else if (deq_go) begin
        if (pop_drains) occ[sel_q]  <= 1'b0;
        else            head[sel_q] <= pop_next;
        nxt[pop_slot] <= enq_ok ? nxt[alloc] : free_head;
        free_head     <= pop_slot;
      end else if (enq_ok) begin
        free_head <= nxt[alloc];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deq_valid <= 1'b0;
      deq_id    <= '0;
      deq_none  <= 1'b0;
      enq_drop  <= 1'b0;
    end else begin
      deq_valid <= deq_go;
      deq_none  <= deq_req && !sel_any;
      enq_drop  <= enq_valid && !enq_ok;
      if (deq_go) deq_id <= pass_thru ? enq_id : idmem[pop_slot];
    end
  end

endmodule

// File: rtl/ready_list_chk.sv
module ready_list_chk #(
  parameter int NQ = 32,
  parameter int QW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enq_valid,
  input logic          deq_req,
  input logic          deq_valid,
  input logic          deq_none,
  input logic          enq_drop,
  input logic          full,
  input logic [NQ-1:0] occ,
  input logic          enq_ok,
  input logic [QW-1:0] enq_qidx
);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(deq_valid && deq_none)); // R6

  AST_EMPTY_DEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_req && occ == '0 && !enq_valid) |=> (deq_none && !deq_valid)); // R6

  AST_NO_REQ_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !deq_req |=> (!deq_valid && !deq_none)); // R6

  AST_SERVED_DEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_req && occ != '0) |=> deq_valid); // R4

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && full) |=> enq_drop); // R7

  AST_NO_DROP_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !full) |=> !enq_drop); // R7

  AST_ENQ_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_ok && !deq_req) |=> occ[$past(enq_qidx)]); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!enq_valid && !deq_req) |=> ($stable(occ) && $stable(full))); // R5

endmodule

bind ready_list ready_list_chk #(.NQ(NQ), .QW(QW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enq_valid (enq_valid),
  .deq_req   (deq_req),
  .deq_valid (deq_valid),
  .deq_none  (deq_none),
  .enq_drop  (enq_drop),
  .full      (full),
  .occ       (occ),
  .enq_ok    (enq_ok),
  .enq_qidx  (enq_qidx)
);

// File: tb/ready_list_tb.sv
module ready_list_tb;

  localparam int NQ = 32;
  localparam int NTASK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enq_valid = 1'b0;
  logic [7:0] enq_id = '0;
  logic [6:0] enq_prio = '0;
  logic       enq_direct = 1'b0;
  logic       deq_req = 1'b0;
  logic       deq_valid;
  logic [7:0] deq_id;
  logic       deq_none;
  logic       enq_drop;
  logic       full;
  logic [31:0] occ;

  int checks = 0;
  int fails = 0;
  logic [7:0] mq [NQ][$];
  int mcount = 0;

  always #5 clk = ~clk;

  ready_list u_dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_id(enq_id),
    .enq_prio(enq_prio), .enq_direct(enq_direct), .deq_req(deq_req),
    .deq_valid(deq_valid), .deq_id(deq_id), .deq_none(deq_none),
    .enq_drop(enq_drop), .full(full), .occ(occ)
  );

  function automatic int band(input int p, input bit dir);
    if (dir) return p % 32;
    return p / 4;
  endfunction

  function automatic logic [31:0] model_occ();
    logic [31:0] r = '0;
    for (int i = 0; i < NQ; i++) r[i] = (mq[i].size() != 0);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit ev, input logic [7:0] id, input int prio,
                      input bit dir, input bit dr, input string tag);
    bit e_valid = 0, e_none = 0, e_drop = 0;
    logic [7:0] e_id = '0;
    @(negedge clk);
    enq_valid = ev; enq_id = id; enq_prio = 7'(prio); enq_direct = dir;
    deq_req = dr;
    if (ev) begin
      if (mcount == NTASK) e_drop = 1;
      else begin
        mq[band(prio, dir)].push_back(id);
        mcount++;
      end
    end
    if (dr) begin
      e_none = 1;
      for (int q = 0; q < NQ; q++) begin
        if (e_none && mq[q].size() != 0) begin
          e_id = mq[q].pop_front();
          e_none = 0; e_valid = 1;
          mcount--;
        end
      end
    end
    @(posedge clk);
    #1;
    chk(deq_valid == e_valid, {tag, " deq_valid"}, 32'(deq_valid), 32'(e_valid));
    chk(deq_none == e_none, {tag, " deq_none"}, 32'(deq_none), 32'(e_none));
    chk(enq_drop == e_drop, {tag, " enq_drop"}, 32'(enq_drop), 32'(e_drop));
    if (e_valid) chk(deq_id == e_id, {tag, " deq_id"}, 32'(deq_id), 32'(e_id));
    chk(occ == model_occ(), {tag, " occ"}, occ, model_occ());
    chk(full == (mcount == NTASK), {tag, " full"}, 32'(full), 32'(mcount == NTASK));
    enq_valid = 0; deq_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk(occ == 0, "R9 occ", occ, 0);
    chk(full == 0 && deq_valid == 0 && deq_none == 0 && enq_drop == 0,
        "R9 outputs", {full, deq_valid, deq_none, enq_drop}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    step(0, 0, 0, 0, 1, "R6 empty deq");
    step(0, 0, 0, 0, 0, "R6 idle");
    // R1 scaled bands
    step(1, 8'h11, 9, 0, 0, "R1 prio9");
    step(1, 8'h12, 127, 0, 0, "R1 prio127");
    step(1, 8'h13, 3, 0, 0, "R1 prio3");
    // R2 direct, high bits ignored
    step(1, 8'h21, 9, 1, 0, "R2 direct9");
    step(1, 8'h22, 7'h69, 1, 0, "R2 direct ignore high");
    // R4 lowest band first
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 1, "R4 drain order");
    step(0, 0, 0, 0, 1, "R6 empty again");
    // R8 same cycle on empty list: pass-through
    step(1, 8'h55, 40, 0, 1, "R8 pass through");
    // R3 FIFO in one queue, plus R8 on a single-entry queue
    step(1, 8'h31, 20, 0, 0, "R3 fill a");
    step(1, 8'h32, 21, 0, 1, "R8 single entry collide");
    step(1, 8'h33, 22, 0, 0, "R3 fill c");
    step(1, 8'h34, 2, 0, 1, "R8 more urgent band");
    step(0, 0, 0, 0, 1, "R3 order");
    step(0, 0, 0, 0, 1, "R3 order");
    step(0, 0, 0, 0, 1, "R6 empty end");
    // R7 fill to capacity, drop, then R10 drain and refill
    for (int k = 0; k < NTASK; k++) step(1, 8'(k), $urandom_range(127), 0, 0, "R7 fill");
    step(1, 8'hee, 5, 0, 0, "R7 drop");
    step(1, 8'hef, 0, 1, 1, "R7 drop with deq");
    for (int k = 0; k < NTASK; k++) step(0, 0, 0, 0, 1, "R10 drain");
    for (int k = 0; k < NTASK; k++) step(1, 8'(k + 100), $urandom_range(127), 1, 0, "R10 refill");
    for (int k = 0; k < NTASK; k++) step(0, 0, 0, 0, 1, "R3 R4 drain");
    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      int pe = (ph % 2) ? 80 : 35;
      for (int k = 0; k < 100; k++) begin
        step($urandom_range(99) < pe, 8'($urandom), $urandom_range(127),
             1'($urandom_range(1)), $urandom_range(99) < 55, "R4 R5 R8 random");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule